// File: doc/BRIEF.md
# Port Address-Line Configuration Register

This block holds a protected six-bit configuration word that decides how an eight-pin general-purpose port is shared. The upper nibble of the port can carry the high external address lines A16 to A19. The lower nibble can carry peripheral chip-enable outputs. Any pin that neither function claims is driven from an ordinary port data register. The block also reports, as an encoded value, the largest memory window that one peripheral chip enable can address under the selected mapping.

The configuration word is written over a simple register bus. A write only lands when the system's timed-access window is open in the same cycle. Software may write the port data register freely. Bits of that register that sit under a pin claimed for address or chip-enable use are locked, so a whole-byte write cannot disturb the claimed pins.

Neither interface carries a data stream. Both are single-cycle write strobes with no back-pressure: every strobe is consumed in the cycle it is presented, and there is no ready signal.

Top module: `addr_line_cfg`

## Requirements
- R1: After reset the configuration reads 8'h00, `mem_size` is 0, `pin_alt` is 8'h00, the port data register reads 8'hFF and every pin drives its port data bit.
- R2: A configuration write with `cfg_ta_open` high loads `cfg_wr_data[5:0]`, and the new value reads back on `cfg_rd_data` from the next cycle.
- R3: A configuration write with `cfg_ta_open` low is ignored, and the previous value keeps reading back.
- R4: Configuration bits 7 and 6 are reserved. They always read 0, and writing 1 to them has no effect.
- R5: The address field is bits 5:3 and holds a code n from 0 to 4. Pin 4+i carries `addr_hi[i]` (A16+i) for every i < n. Code 0 keeps all four upper pins as I/O, and code 4 places A19..A16 on pins 7..4.
- R6: Address field codes 5, 6 and 7 behave exactly like code 0, including the memory size.
- R7: `mem_size` encodes the maximum memory per peripheral chip enable: 0=32kB, 1=128kB, 2=256kB, 3=512kB, 4=1MB. It follows the effective address code.
- R8: A port data write updates only the bits whose pins are unclaimed. Bits under claimed pins keep their stored value, which is visible on `port_rd_data`.
- R9: The chip-enable field is bits 2:0. A value c claims pins 0..k-1, where k is c for c from 0 to 4 and k is 4 for c from 5 to 7. Each claimed pin i drives `ce_drv[i]` and is locked in the same way as an address pin.
- R10: A new mapping and its lock take effect in the cycle after the accepted write. A port write in the same cycle as a configuration write is masked by the previous lock.
- R11: An unclaimed pin i drives bit i of the port data register, and `pin_alt[i]` is 1 exactly when pin i is claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_ta_open | input | 1 | Timed-access window open this cycle |
| cfg_wr_data | input | 8 | Configuration write data |
| cfg_rd_data | output | 8 | Configuration read-back |
| port_wr_en | input | 1 | Port data register write strobe |
| port_wr_data | input | 8 | Port data write value |
| port_rd_data | output | 8 | Port data register contents |
| addr_hi | input | 4 | Address bits A19..A16 (bit 0 = A16) |
| ce_drv | input | 4 | Peripheral chip-enable levels for pins 0..3 |
| pin_out | output | 8 | Resolved pin output values |
| pin_alt | output | 8 | Per-pin flag: pin is claimed by an alternate function |
| mem_size | output | 3 | Encoded maximum memory per chip enable |

## Verification
The address field is driven through all eight codes. The five valid codes separate one mapping width from the next, and codes 5 to 7 show whether they fall back to code 0 or leak into a wider mapping. The chip-enable field is also swept across all eight values, which separates the saturating codes above 4 from a plain truncation. Port writes are mixed in with random data while different locks are active, so a bit that is wrongly masked or wrongly left writable shows up on `port_rd_data`. Protected writes are offered with the window open and closed, and with reserved bits set. One directed case puts a configuration write and a port write in the same cycle, which shows whether the new lock is applied one cycle too early.

// File: rtl/alc_pkg.sv
package alc_pkg;
  localparam int PORT_W  = 8;
  localparam int NIB_W   = PORT_W / 2;
  localparam int FIELD_W = 3;
  localparam int CFG_W   = 2 * FIELD_W;
  localparam logic [FIELD_W-1:0] MAX_CODE = FIELD_W'(NIB_W);

  typedef enum logic [FIELD_W-1:0] {
    SZ_32K  = 3'd0,
    SZ_128K = 3'd1,
    SZ_256K = 3'd2,
    SZ_512K = 3'd3,
    SZ_1M   = 3'd4
  } mem_size_e;

  // Address code outside the valid set collapses to the all-I/O mapping.
  function automatic logic [FIELD_W-1:0] norm_addr(input logic [FIELD_W-1:0] c);
    return (c > MAX_CODE) ? '0 : c;
  endfunction

  // Chip-enable code saturates at the nibble width.
  function automatic logic [FIELD_W-1:0] sat_ce(input logic [FIELD_W-1:0] c);
    return (c > MAX_CODE) ? MAX_CODE : c;
  endfunction
endpackage

// File: rtl/alc_cfg_reg.sv
module alc_cfg_reg
  import alc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              ta_open,
  input  logic [PORT_W-1:0] wr_data,
  output logic [FIELD_W-1:0] addr_fld,
  output logic [FIELD_W-1:0] ce_fld,
  output logic [PORT_W-1:0] rd_data
);
  logic [CFG_W-1:0] cfg_q;
  logic             accept;

  assign accept = wr_en & ta_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (accept) cfg_q <= wr_data[CFG_W-1:0];
  end

  assign addr_fld = cfg_q[CFG_W-1:FIELD_W];
  assign ce_fld   = cfg_q[FIELD_W-1:0];
  assign rd_data  = {{(PORT_W-CFG_W){1'b0}}, cfg_q};

  AST_UNGUARDED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ta_open) |=> ($stable(addr_fld) && $stable(ce_fld))); // R3

  AST_GUARDED_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ta_open) |=> ({addr_fld, ce_fld} == $past(wr_data[CFG_W-1:0]))); // R2
endmodule

// File: rtl/alc_pin_map.sv
module alc_pin_map
  import alc_pkg::*;
(
  input  logic [FIELD_W-1:0] addr_fld,
  input  logic [FIELD_W-1:0] ce_fld,
  output logic [NIB_W-1:0]   addr_mask,
  output logic [NIB_W-1:0]   ce_mask,
  output logic [FIELD_W-1:0] size_code
);
  logic [FIELD_W-1:0] n_addr;
  logic [FIELD_W-1:0] n_ce;

  assign n_addr = norm_addr(addr_fld);
  assign n_ce   = sat_ce(ce_fld);

  for (genvar i = 0; i < NIB_W; i++) begin : g_mask
    assign addr_mask[i] = (n_addr > FIELD_W'(i));
    assign ce_mask[i]   = (n_ce   > FIELD_W'(i));
  end

  mem_size_e sz;
  assign sz        = mem_size_e'(n_addr);
  assign size_code = sz;

  always_comb begin
    if (!$isunknown(addr_fld)) begin
      AST_SIZE_IN_RANGE: assert (size_code <= MAX_CODE); // R7
      AST_ADDR_PINS_CONTIGUOUS: assert (((addr_mask + NIB_W'(1)) & addr_mask) == '0); // R5
      if (addr_fld > MAX_CODE) begin
        AST_BAD_CODE_FALLBACK: assert (addr_mask == '0 && size_code == '0); // R6
      end
    end
  end
endmodule

// File: rtl/alc_port_reg.sv
module alc_port_reg
  import alc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] wr_data,
  input  logic [PORT_W-1:0] lock_mask,
  output logic [PORT_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '1;
    else if (wr_en) q <= (q & lock_mask) | (wr_data & ~lock_mask);
  end

  AST_LOCKED_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((q ^ $past(q)) & $past(lock_mask)) == '0)); // R8
endmodule

// File: rtl/addr_line_cfg.sv
module addr_line_cfg
  import alc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic              cfg_ta_open,
  input  logic [PORT_W-1:0] cfg_wr_data,
  output logic [PORT_W-1:0] cfg_rd_data,
  input  logic              port_wr_en,
  input  logic [PORT_W-1:0] port_wr_data,
  output logic [PORT_W-1:0] port_rd_data,
  input  logic [NIB_W-1:0]  addr_hi,
  input  logic [NIB_W-1:0]  ce_drv,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_alt,
  output logic [FIELD_W-1:0] mem_size
);
  logic [FIELD_W-1:0] addr_fld, ce_fld;
  logic [NIB_W-1:0]   addr_mask, ce_mask;
  logic [PORT_W-1:0]  lock_mask, port_q;

  alc_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .ta_open(cfg_ta_open),
    .wr_data(cfg_wr_data), .addr_fld(addr_fld), .ce_fld(ce_fld), .rd_data(cfg_rd_data)
  );

  alc_pin_map u_map (
    .addr_fld(addr_fld), .ce_fld(ce_fld),
    .addr_mask(addr_mask), .ce_mask(ce_mask), .size_code(mem_size)
  );

  assign lock_mask = {addr_mask, ce_mask};

  alc_port_reg u_port (
    .clk(clk), .rst_n(rst_n), .wr_en(port_wr_en), .wr_data(port_wr_data),
    .lock_mask(lock_mask), .q(port_q)
  );

  for (genvar i = 0; i < NIB_W; i++) begin : g_pin
    assign pin_out[i]       = ce_mask[i]   ? ce_drv[i]  : port_q[i];
    assign pin_out[i+NIB_W] = addr_mask[i] ? addr_hi[i] : port_q[i+NIB_W];
  end

  assign pin_alt      = lock_mask;
  assign port_rd_data = port_q;

  AST_MAP_CHANGES_ONLY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr_en && cfg_ta_open) |=> $stable(pin_alt)); // R10
endmodule

// File: tb/addr_line_cfg_tb_top.sv
module addr_line_cfg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 3000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr_en = 1'b0, cfg_ta_open = 1'b0, port_wr_en = 1'b0;
  logic [7:0] cfg_wr_data = '0, port_wr_data = '0;
  logic [3:0] addr_hi = '0, ce_drv = '0;
  logic [7:0] cfg_rd_data, port_rd_data, pin_out, pin_alt;
  logic [2:0] mem_size;

  int n_vec = 0, n_fail = 0;
  logic [5:0] m_cfg;
  logic [7:0] m_port;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_line_cfg dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_ta_open(cfg_ta_open),
    .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data), .port_wr_en(port_wr_en),
    .port_wr_data(port_wr_data), .port_rd_data(port_rd_data), .addr_hi(addr_hi),
    .ce_drv(ce_drv), .pin_out(pin_out), .pin_alt(pin_alt), .mem_size(mem_size)
  );

  function automatic logic [2:0] eff_addr(input logic [5:0] c);
    return (c[5:3] > 3'd4) ? 3'd0 : c[5:3];
  endfunction

  function automatic logic [7:0] exp_lock(input logic [5:0] c);
    logic [2:0] k;
    logic [7:0] m;
    k = (c[2:0] > 3'd4) ? 3'd4 : c[2:0];
    m = '0;
    for (int i = 0; i < 4; i++) begin
      if (eff_addr(c) > 3'(i)) m[i+4] = 1'b1;
      if (k > 3'(i)) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [7:0] exp_pins(input logic [5:0] c, input logic [7:0] p,
                                          input logic [3:0] a, input logic [3:0] e);
    logic [7:0] l, r;
    l = exp_lock(c);
    for (int i = 0; i < 4; i++) begin
      r[i]   = l[i]   ? e[i] : p[i];
      r[i+4] = l[i+4] ? a[i] : p[i+4];
    end
    return r;
  endfunction

  task automatic cmp8(input string tag, input string what, input logic [7:0] got, input logic [7:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    cmp8(tag == "" ? "R2" : tag, "cfg_rd_data", cfg_rd_data, {2'b00, m_cfg});
    cmp8(tag == "" ? "R7" : tag, "mem_size", {5'd0, mem_size}, {5'd0, eff_addr(m_cfg)});
    cmp8(tag == "" ? "R5" : tag, "pin_alt", pin_alt, exp_lock(m_cfg));
    cmp8(tag == "" ? "R11" : tag, "pin_out", pin_out, exp_pins(m_cfg, m_port, addr_hi, ce_drv));
    cmp8(tag == "" ? "R8" : tag, "port_rd_data", port_rd_data, m_port);
  endtask

  task automatic step(input logic cw, input logic ta, input logic [7:0] cd,
                      input logic pw, input logic [7:0] pd,
                      input logic [3:0] a, input logic [3:0] e, input string tag);
    logic [7:0] l;
    @(negedge clk);
    cfg_wr_en = cw; cfg_ta_open = ta; cfg_wr_data = cd;
    port_wr_en = pw; port_wr_data = pd; addr_hi = a; ce_drv = e;
    @(posedge clk);
    l = exp_lock(m_cfg);
    if (pw) m_port = (m_port & l) | (pd & ~l);
    if (cw && ta) m_cfg = cd[5:0];
    @(negedge clk);
    cfg_wr_en = 1'b0; port_wr_en = 1'b0;
    check_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    m_cfg = '0; m_port = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R3: closed window, value persists
    step(1, 0, 8'h24, 0, 8'h00, 4'hA, 4'h5, "R3");
    step(1, 1, 8'h24, 0, 8'h00, 4'hA, 4'h5, "R2");
    step(1, 0, 8'h00, 0, 8'h00, 4'hA, 4'h5, "R3");
    // R4: reserved bits set in write data
    step(1, 1, 8'hE3, 0, 8'h00, 4'h3, 4'hC, "R4");
    // R5: each valid address code
    for (int c = 0; c <= 4; c++) begin
      step(1, 1, 8'(c << 3), 0, 8'h00, 4'hF, 4'h0, "R5");
      step(0, 0, 8'h00, 1, 8'h00, 4'hF, 4'h0, "R5");
    end
    // R6: invalid codes fall back to all I/O, 32kB
    for (int c = 5; c <= 7; c++) begin
      step(1, 1, 8'(c << 3), 0, 8'h00, 4'hF, 4'hF, "R6");
      step(0, 0, 8'h00, 1, 8'h5A, 4'hF, 4'hF, "R6");
    end
    // R9: chip-enable field sweep incl. saturating values
    for (int c = 0; c <= 7; c++) begin
      step(1, 1, 8'(c), 0, 8'h00, 4'h0, 4'hF, "R9");
      step(0, 0, 8'h00, 1, 8'hC3, 4'h0, 4'h6, "R9");
    end
    // R8: full lock, byte write changes nothing
    step(1, 1, 8'h24, 0, 8'h00, 4'h9, 4'h6, "R8");
    step(0, 0, 8'h00, 1, 8'h00, 4'h9, 4'h6, "R8");
    // R10: same-cycle cfg and port write uses the old (full) lock
    step(1, 1, 8'h00, 1, 8'h00, 4'h9, 4'h6, "R10");
    step(0, 0, 8'h00, 1, 8'h00, 4'h9, 4'h6, "R10");

    for (int n = 0; n < N_RANDOM; n++) begin
      logic [7:0] cd;
      cd = 8'($urandom);
      step(($urandom % 3) == 0, $urandom % 2, cd, ($urandom % 2) == 1, 8'($urandom),
           4'($urandom), 4'($urandom), "");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule